// File: doc/BRIEF.md
# Interrupt Descriptor Queue with Overflow Marking

This block holds the interrupt descriptors that on-chip event sources raise until they can be written out to an interrupt queue in shared memory. Each source hands over a 31-bit payload. The block stores it as a 32-bit descriptor whose top bit is the loss flag, and that flag is always clear when an entry enters. The oldest held descriptor is offered on a write-request port. It leaves the queue in the cycle the memory side acknowledges it.

When the queue is full and no entry leaves in that cycle, an arriving descriptor is discarded. The block then sets the loss flag inside the newest descriptor still held, so the drop stays visible in the memory queue. No other bit of that descriptor changes.

A small read-only status word gathers three sticky conditions: a lost interrupt, a bus parity error (only while parity response is enabled), and a completed service request. Events are first collected in a pending set. They are folded into the visible word only when a descriptor is written out. The word clears on hardware reset, on soft reset, and whenever the queue configuration is written.

Top module: `irq_desc_queue`

## Requirements
- R1: `wr_req` is high exactly when the queue holds at least one descriptor. `wr_desc` shows the oldest held descriptor, and that descriptor leaves in any cycle where `wr_req` and `wr_ack` are both high. Descriptors leave in arrival order.
- R2: Up to DEPTH (default 8) descriptors are held. An accepted descriptor is stored as bit 31 = 0 and bits 30:0 = `irq_desc`.
- R3: When `irq_valid` is high, the queue is full and no descriptor leaves in that cycle, the incoming payload is discarded. Bit 31 of the newest held descriptor becomes 1.
- R4: Setting the loss flag leaves bits 30:0 of the affected descriptor unchanged. A descriptor waiting on `wr_req` without `wr_ack` keeps bits 30:0 stable.
- R5: When the queue is full and a descriptor leaves in the same cycle that `irq_valid` is high, the new payload is accepted and no loss is flagged.
- R6: `status` bit 0 = lost interrupt, bit 1 = parity error, bit 2 = service acknowledge. The visible word changes only at a write-out edge (`wr_req` and `wr_ack` high). At that edge it absorbs every event pending since the previous write-out, including events in the same cycle.
- R7: A `par_err_evt` pulse while `par_resp_en` is 0 never sets status bit 1.
- R8: A `svc_done_evt` pulse sets status bit 2 at the next write-out.
- R9: Status bits are sticky. Without a clear they never return to 0, and between write-outs they do not change.
- R10: A `cfg_wr` pulse clears the status word and all pending events from the next cycle on. Held descriptors are unaffected.
- R11: A `soft_rst` pulse clears the status word and pending events and empties the queue from the next cycle on.
- R12: While `rst_n` is low, `wr_req` is 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| soft_rst | input | 1 | Soft chip reset pulse: empties the queue, clears status |
| cfg_wr | input | 1 | Queue configuration written: clears status |
| irq_valid | input | 1 | New interrupt descriptor offered |
| irq_desc | input | 31 | Descriptor payload, bits 30:0 |
| wr_req | output | 1 | Write-out request to shared memory |
| wr_desc | output | 32 | Oldest held descriptor, bit 31 = loss flag |
| wr_ack | input | 1 | Write-out accepted this cycle |
| par_resp_en | input | 1 | Parity-error response enable |
| par_err_evt | input | 1 | Parity error detected (pulse) |
| svc_done_evt | input | 1 | Host service request completed (pulse) |
| status | output | 3 | Sticky status: {service ack, parity error, lost} |

## Verification
A pointer or count that goes wrong shows up at once on `wr_desc`. The next write-out presents a stale, repeated or out-of-order payload, and `wr_req` stays high on an empty queue or low on a filled one. A loss mark written into the wrong slot appears as bit 31 on a neighbouring descriptor, which is only seen when that slot reaches the head, up to DEPTH write-outs later. A pending-event fault stays hidden until the next write-out edge. Because of that, the bench always forces a write-out after each event and then reads the word.

// File: rtl/irqq_pkg.sv
package irqq_pkg;
  localparam int DESC_W    = 32;
  localparam int STAT_W    = 3;
  localparam int ST_LOST   = 0;
  localparam int ST_PERR   = 1;
  localparam int ST_SACK   = 2;

  // Merge newly seen events into a sticky pending set.
  function automatic logic [STAT_W-1:0] stat_merge(input logic [STAT_W-1:0] cur,
                                                   input logic lost, input logic perr,
                                                   input logic sack);
    logic [STAT_W-1:0] ev;
    ev = '0;
    ev[ST_LOST] = lost;
    ev[ST_PERR] = perr;
    ev[ST_SACK] = sack;
    return cur | ev;
  endfunction
endpackage

// File: rtl/irqq_fifo.sv
module irqq_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_vld,
  input  logic [DW-2:0] push_data,
  input  logic          pop_rdy,
  output logic          head_vld,
  output logic [DW-1:0] head_data,
  output logic          drain,
  output logic          drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          full, push;
  logic [PW-1:0] newest;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_prev(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign head_vld  = (count != '0);
  assign head_data = mem[rd_ptr];
  assign drain     = head_vld && pop_rdy && !flush;
  assign push      = push_vld && !flush && (!full || drain);
  assign drop      = push_vld && !flush && full && !drain;
  assign newest    = ptr_prev(wr_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)  wr_ptr <= ptr_next(wr_ptr);
      if (drain) rd_ptr <= ptr_next(rd_ptr);
      case ({push, drain})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[wr_ptr] <= {1'b0, push_data};
    end else if (drop) begin
      mem[newest][DW-1] <= 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R3
  drop_marks_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> mem[$past(newest)][DW-1]);
  // R5
  full_drain_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop_rdy && push_vld) |-> !drop);
  // R4
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && !pop_rdy && !flush) |=> head_data[DW-2:0] == $past(head_data[DW-2:0]));
endmodule

// File: rtl/irqq_status.sv
module irqq_status
  import irqq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              drain,
  input  logic              lost_evt,
  input  logic              perr_evt,
  input  logic              perr_en,
  input  logic              sack_evt,
  output logic [STAT_W-1:0] stat
);
  logic [STAT_W-1:0] pend, pend_nxt;

  assign pend_nxt = stat_merge(pend, lost_evt, perr_evt && perr_en, sack_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      stat <= '0;
    end else if (clr) begin
      pend <= '0;
      stat <= '0;
    end else if (drain) begin
      pend <= '0;
      stat <= stat | pend_nxt;
    end else begin
      pend <= pend_nxt;
    end
  end

  // R9
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain && !clr) |=> $stable(stat));
  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stat == '0));
  // R6
  stat_rise_on_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drain |=> ((stat & ~$past(stat)) == '0));
endmodule

// File: rtl/irq_desc_queue.sv
module irq_desc_queue
  import irqq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_wr,
  input  logic              irq_valid,
  input  logic [DESC_W-2:0] irq_desc,
  output logic              wr_req,
  output logic [DESC_W-1:0] wr_desc,
  input  logic              wr_ack,
  input  logic              par_resp_en,
  input  logic              par_err_evt,
  input  logic              svc_done_evt,
  output logic [STAT_W-1:0] status
);
  logic drain_w, drop_w, clr_w;

  assign clr_w = soft_rst || cfg_wr;

  irqq_fifo #(.DW(DESC_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (soft_rst),
    .push_vld  (irq_valid),
    .push_data (irq_desc),
    .pop_rdy   (wr_ack),
    .head_vld  (wr_req),
    .head_data (wr_desc),
    .drain     (drain_w),
    .drop      (drop_w)
  );

  irqq_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_w),
    .drain    (drain_w),
    .lost_evt (drop_w),
    .perr_evt (par_err_evt),
    .perr_en  (par_resp_en),
    .sack_evt (svc_done_evt),
    .stat     (status)
  );

  // R7
  perr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_w && !status[ST_PERR] && !par_resp_en && !par_err_evt && !cfg_wr && !soft_rst
     && $past(!par_resp_en) && $past(!status[ST_PERR]) && $past(drain_w))
    |=> !status[ST_PERR]);
endmodule

// File: tb/irq_desc_queue_bench.sv
module irq_desc_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst, cfg_wr, irq_valid, wr_ack;
  logic        par_resp_en, par_err_evt, svc_done_evt;
  logic [30:0] irq_desc;
  logic        wr_req;
  logic [31:0] wr_desc;
  logic [2:0]  status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [30:0] TBL [8] = '{31'h0000_0011, 31'h7FFF_FFFF, 31'h2AAA_AAAA,
                                      31'h1555_5555, 31'h0000_0000, 31'h0BAD_F00D,
                                      31'h3333_0001, 31'h4000_0007};
  localparam logic [30:0] DROPPED = 31'h1234_5678;
  localparam logic [30:0] LATE    = 31'h0C0F_FEE5;

  always #2.5 clk = ~clk;

  irq_desc_queue u_irq_desc_queue (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
    .irq_valid(irq_valid), .irq_desc(irq_desc), .wr_req(wr_req), .wr_desc(wr_desc),
    .wr_ack(wr_ack), .par_resp_en(par_resp_en), .par_err_evt(par_err_evt),
    .svc_done_evt(svc_done_evt), .status(status)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [30:0] d);
    irq_valid = 1'b1; irq_desc = d; tick(); irq_valid = 1'b0;
  endtask

  task automatic pop();
    wr_ack = 1'b1; tick(); wr_ack = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL R1: watchdog expired, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; cfg_wr = 1'b0; irq_valid = 1'b0; wr_ack = 1'b0;
    par_resp_en = 1'b0; par_err_evt = 1'b0; svc_done_evt = 1'b0; irq_desc = '0;
    tick(); tick(); tick();
    chk("R12 wr_req in reset", {31'b0, wr_req}, 32'd0);
    chk("R12 status in reset", {29'b0, status}, 32'd0);
    rst_n = 1'b1;
    tick();

    // Table walk: fill the queue (R1, R2)
    for (int i = 0; i < 8; i++) push(TBL[i]);
    chk("R1 wr_req when filled", {31'b0, wr_req}, 32'd1);
    chk("R2 head descriptor", wr_desc, {1'b0, TBL[0]});

    // Overflow with no drain: dropped, newest marked (R3)
    push(DROPPED);
    chk("R6 status before any write-out", {29'b0, status}, 32'd0);
    chk("R3 head unchanged after drop", wr_desc, {1'b0, TBL[0]});
    for (int i = 0; i < 8; i++) begin
      chk("R1 wr_req while draining", {31'b0, wr_req}, 32'd1);
      chk("R3 R4 drained descriptor", wr_desc, {(i == 7), TBL[i]});
      pop();
      if (i == 0) chk("R6 lost bit after first write-out", {29'b0, status}, 32'd1);
    end
    chk("R1 wr_req after empty", {31'b0, wr_req}, 32'd0);

    // Full with simultaneous drain: accepted (R5)
    for (int i = 0; i < 8; i++) push(TBL[i]);
    irq_valid = 1'b1; irq_desc = LATE; wr_ack = 1'b1;
    tick();
    irq_valid = 1'b0; wr_ack = 1'b0;
    for (int i = 1; i < 9; i++) begin
      chk("R5 order after full drain-accept", wr_desc, {1'b0, (i == 8) ? LATE : TBL[i]});
      pop();
    end
    chk("R5 queue empty", {31'b0, wr_req}, 32'd0);
    chk("R9 lost stays sticky", {29'b0, status}, 32'd1);

    // Configuration write clears status only (R10)
    push(TBL[3]);
    cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
    chk("R10 status cleared", {29'b0, status}, 32'd0);
    chk("R10 entry kept", {wr_req, wr_desc[30:0]}, {1'b1, TBL[3]});
    pop();
    chk("R10 no stale pending", {29'b0, status}, 32'd0);

    // Parity masking (R7)
    par_err_evt = 1'b1; tick(); par_err_evt = 1'b0;
    push(TBL[1]); pop();
    chk("R7 parity masked", {29'b0, status}, 32'd0);
    par_resp_en = 1'b1;
    par_err_evt = 1'b1; tick(); par_err_evt = 1'b0;
    chk("R6 parity deferred until write-out", {29'b0, status}, 32'd0);
    push(TBL[2]); pop();
    chk("R6 parity after write-out", {29'b0, status}, 32'd2);

    // Service acknowledge (R8) and stickiness (R9)
    svc_done_evt = 1'b1; tick(); svc_done_evt = 1'b0;
    push(TBL[4]); pop();
    chk("R8 service ack", {29'b0, status}, 32'd6);
    push(TBL[5]); pop();
    chk("R9 sticky over quiet write-out", {29'b0, status}, 32'd6);

    // Soft reset (R11)
    push(TBL[0]); push(TBL[1]); push(TBL[2]);
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    chk("R11 queue emptied", {31'b0, wr_req}, 32'd0);
    chk("R11 status cleared", {29'b0, status}, 32'd0);
    push(TBL[6]);
    chk("R11 fresh head after flush", wr_desc, {1'b0, TBL[6]});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule